// File: doc/BRIEF.md
# Load/Store-Multiple Micro-op Sequencer

This block turns one decoded block-transfer instruction into a run of simple micro-ops, handing out one per cycle over a valid/ready output. The instruction gives a base register index, a 16-bit register list, and five flags: pre-indexing, direction (up or down), user bank, base writeback, and load versus store.

The sequence always opens by copying the base register into a temporary register (index 16). Every transfer then addresses memory at a byte offset from that temporary. Registers are transferred from the lowest index to the highest. An optional closing micro-op moves the real base register by four bytes per listed register. The consumer is expected to perform the memory and register-file work, and any exception return.

The block takes a new instruction only when it is idle. It keeps each micro-op steady on its outputs until the consumer accepts it.

Top module: `lsm_sequencer`

## Requirements
- R1: One instruction yields exactly popcount(list) + 1 micro-ops, plus one more when writeback is set.
- R2: The first micro-op has kind COPY (code 0), out_reg 16 (the temporary), out_base equal to the instruction's base, and out_off 0.
- R3: Each set bit of the list yields one transfer micro-op, in ascending register order. out_reg is the register index and out_base is 16. The kind is LOAD (code 1) for a load and STORE (code 3) for a store.
- R4: The first transfer's offset starts at 0. When the direction is down, it starts instead at popcount*4-4. When pre-indexing is clear, 4 is added to that starting value.
- R5: Each later transfer's offset is 4 more than the previous one when the direction is up, and 4 less when it is down. out_up equals the direction flag on every micro-op.
- R6: out_usr is 1 on every transfer when the user flag is set and bit 15 of the list is clear. It is 0 in every other case and on every non-transfer micro-op.
- R7: When the user flag is set, bit 15 is in the list and the operation is a load, the transfer of register 15 has kind LOAD_RET (code 2). No other micro-op has that kind.
- R8: With writeback, the final micro-op has kind ADDI (code 4) for up or SUBI (code 5) for down. Its out_reg and out_base both equal the base, and its out_off is popcount*4.
- R9: out_last is 1 on the final micro-op of each instruction and 0 on every other micro-op.
- R10: in_ready is 1 only when no micro-op is pending. in_valid has no effect while busy. A micro-op held with out_ready low keeps all its fields unchanged.
- R11: An empty list produces only the COPY micro-op, followed by an ADDI or SUBI with offset 0 when writeback is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Block idle, instruction taken when in_valid is high |
| in_base | input | 4 | Base register index |
| in_list | input | 16 | Register list |
| in_pre | input | 1 | Pre-indexing |
| in_up | input | 1 | Direction up (1) or down (0) |
| in_user | input | 1 | User-bank / exception-return form |
| in_wb | input | 1 | Write the base back |
| in_load | input | 1 | Load (1) or store (0) |
| out_valid | output | 1 | Micro-op present |
| out_ready | input | 1 | Consumer accepts the micro-op |
| out_kind | output | 3 | Micro-op kind code |
| out_reg | output | 5 | Destination or source register (16 = temporary) |
| out_base | output | 5 | Address base register (16 = temporary) |
| out_off | output | 8 | Byte offset or immediate |
| out_up | output | 1 | Direction of the instruction |
| out_usr | output | 1 | Access the user-mode register bank |
| out_last | output | 1 | Final micro-op of the instruction |

## Verification
The exception-return kind and the last flag can land on the same micro-op. This happens with a user-form load whose list ends at register 15 and has no writeback. The bench provokes it directly and also runs the writeback variant, where the flags must separate onto consecutive micro-ops. A behavioural model builds the expected micro-op queue for each instruction and compares every field on every clock. It does this while out_ready stalls in a repeating pattern and in_valid stays high with other contents during the whole run.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
    parameter int NREGS = 16;
    parameter int OFF_W = 8;
    localparam int REG_W = $clog2(NREGS);
    localparam int IDX_W = REG_W + 1;
    localparam int POP_W = $clog2(NREGS + 1);
    localparam int WORD_BYTES = 4;

    typedef enum logic [2:0] {
        UOP_COPY     = 3'd0,
        UOP_LOAD     = 3'd1,
        UOP_LOAD_RET = 3'd2,
        UOP_STORE    = 3'd3,
        UOP_ADDI     = 3'd4,
        UOP_SUBI     = 3'd5
    } uop_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE, ST_COPY, ST_XFER, ST_WB
    } seq_state_e;

    typedef struct packed {
        uop_kind_e        kind;
        logic [IDX_W-1:0] reg_idx;
        logic [IDX_W-1:0] base_idx;
        logic [OFF_W-1:0] off;
        logic             up;
        logic             usr;
        logic             last;
    } uop_t;

    localparam logic [IDX_W-1:0] TEMP_IDX = IDX_W'(NREGS);

    function automatic logic [OFF_W-1:0] span_bytes(input logic [POP_W-1:0] pop);
        return OFF_W'(pop) * OFF_W'(WORD_BYTES);
    endfunction

    function automatic logic [OFF_W-1:0] first_offset(input logic [POP_W-1:0] pop,
                                                      input logic up, input logic pre);
        logic [OFF_W-1:0] o;
        o = up ? '0 : span_bytes(pop) - OFF_W'(WORD_BYTES);
        if (!pre) o = o + OFF_W'(WORD_BYTES);
        return o;
    endfunction
endpackage

// File: rtl/lsm_popcount.sv
module lsm_popcount #(
    parameter int W = 16,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] count
);
    always_comb begin
        count = '0;
        for (int i = 0; i < W; i++) begin
            count = count + CW'(vec[i]);
        end
    end
endmodule

// File: rtl/lsm_lowest.sv
module lsm_lowest #(
    parameter int W = 16,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          only_one
);
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end

    assign only_one = ((vec & (vec - W'(1))) == '0);
endmodule

// File: rtl/lsm_sequencer.sv
module lsm_sequencer
    import lsm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [REG_W-1:0]     in_base,
    input  logic [NREGS-1:0]     in_list,
    input  logic                 in_pre,
    input  logic                 in_up,
    input  logic                 in_user,
    input  logic                 in_wb,
    input  logic                 in_load,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [2:0]           out_kind,
    output logic [IDX_W-1:0]     out_reg,
    output logic [IDX_W-1:0]     out_base,
    output logic [OFF_W-1:0]     out_off,
    output logic                 out_up,
    output logic                 out_usr,
    output logic                 out_last
);
    seq_state_e        state;
    logic [NREGS-1:0]  rem;
    logic [OFF_W-1:0]  cur_off;
    logic [POP_W-1:0]  pop_q;
    logic [REG_W-1:0]  rn_q;
    logic              up_q, wb_q, load_q, force_usr_q, ret_q;

    logic [POP_W-1:0]  in_pop;
    logic [REG_W-1:0]  pick_idx;
    logic              pick_only;
    logic              accept, fire;
    uop_t              uop;

    lsm_popcount #(.W(NREGS)) u_pop (.vec(in_list), .count(in_pop));
    lsm_lowest   #(.W(NREGS)) u_pick (.vec(rem), .idx(pick_idx), .only_one(pick_only));

    assign in_ready  = (state == ST_IDLE);
    assign out_valid = (state != ST_IDLE);
    assign accept    = in_valid && in_ready;
    assign fire      = out_valid && out_ready;

    always_comb begin
        uop          = '0;
        uop.up       = up_q;
        case (state)
            ST_COPY: begin
                uop.kind     = UOP_COPY;
                uop.reg_idx  = TEMP_IDX;
                uop.base_idx = IDX_W'(rn_q);
                uop.last     = (rem == '0) && !wb_q;
            end
            ST_XFER: begin
                if (!load_q)
                    uop.kind = UOP_STORE;
                else if (ret_q && pick_idx == REG_W'(NREGS - 1))
                    uop.kind = UOP_LOAD_RET;
                else
                    uop.kind = UOP_LOAD;
                uop.reg_idx  = IDX_W'(pick_idx);
                uop.base_idx = TEMP_IDX;
                uop.off      = cur_off;
                uop.usr      = force_usr_q;
                uop.last     = pick_only && !wb_q;
            end
            ST_WB: begin
                uop.kind     = up_q ? UOP_ADDI : UOP_SUBI;
                uop.reg_idx  = IDX_W'(rn_q);
                uop.base_idx = IDX_W'(rn_q);
                uop.off      = span_bytes(pop_q);
                uop.last     = 1'b1;
            end
            default: uop.kind = UOP_COPY;
        endcase
    end

    assign out_kind = uop.kind;
    assign out_reg  = uop.reg_idx;
    assign out_base = uop.base_idx;
    assign out_off  = uop.off;
    assign out_up   = uop.up;
    assign out_usr  = uop.usr;
    assign out_last = uop.last;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            rem         <= '0;
            cur_off     <= '0;
            pop_q       <= '0;
            rn_q        <= '0;
            up_q        <= 1'b0;
            wb_q        <= 1'b0;
            load_q      <= 1'b0;
            force_usr_q <= 1'b0;
            ret_q       <= 1'b0;
        end else if (accept) begin
            state       <= ST_COPY;
            rem         <= in_list;
            cur_off     <= first_offset(in_pop, in_up, in_pre);
            pop_q       <= in_pop;
            rn_q        <= in_base;
            up_q        <= in_up;
            wb_q        <= in_wb;
            load_q      <= in_load;
            force_usr_q <= in_user && !in_list[NREGS-1];
            ret_q       <= in_user && in_list[NREGS-1];
        end else if (fire) begin
            case (state)
                ST_COPY: begin
                    if (rem != '0)  state <= ST_XFER;
                    else if (wb_q)  state <= ST_WB;
                    else            state <= ST_IDLE;
                end
                ST_XFER: begin
                    rem     <= rem & (rem - NREGS'(1));
                    cur_off <= up_q ? cur_off + OFF_W'(WORD_BYTES)
                                    : cur_off - OFF_W'(WORD_BYTES);
                    if (pick_only) state <= wb_q ? ST_WB : ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    logic is_xfer;
    assign is_xfer = out_valid && (out_kind == UOP_LOAD || out_kind == UOP_LOAD_RET
                                   || out_kind == UOP_STORE);

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_kind) && $stable(out_reg)
            && $stable(out_base) && $stable(out_off) && $stable(out_last) && $stable(out_usr));

    p_copy_first_r2: assert property (@(posedge clk) disable iff (rst)
        accept |=> out_valid && out_kind == UOP_COPY && out_reg == TEMP_IDX && out_off == '0);

    p_last_idle_r9: assert property (@(posedge clk) disable iff (rst)
        fire && out_last |=> in_ready);

    p_ret_reg_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_kind == UOP_LOAD_RET |-> out_reg == IDX_W'(NREGS - 1) && !out_usr);

    p_step_r5: assert property (@(posedge clk) disable iff (rst)
        fire && is_xfer |=> !is_xfer || out_off == (out_up ? $past(out_off) + OFF_W'(WORD_BYTES)
                                                          : $past(out_off) - OFF_W'(WORD_BYTES)));
endmodule

// File: tb/lsm_sequencer_test.sv
module lsm_sequencer_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [3:0]  in_base = '0;
    logic [15:0] in_list = '0;
    logic        in_pre = 1'b0, in_up = 1'b0, in_user = 1'b0, in_wb = 1'b0, in_load = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [2:0]  out_kind;
    logic [4:0]  out_reg, out_base;
    logic [7:0]  out_off;
    logic        out_up, out_usr, out_last;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    typedef struct {
        int kind; int rg; int base; int off; int up; int usr; int last; string tag;
    } exp_t;
    exp_t q[$];

    lsm_sequencer uut (.*);

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: run hung (actual %0d cycles, expected < 100000)", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic run(input logic [3:0] rn, input logic [15:0] lst, input bit pre,
                       input bit up, input bit usr, input bit wb, input bit ld, input int stall);
        int pop = 0;
        int off;
        int c = 0;
        int fired = 0;
        bit r15 = lst[15];
        exp_t e;
        q.delete();
        for (int r = 0; r < 16; r++) if (lst[r]) pop++;
        off = up ? 0 : pop * 4 - 4;
        if (!pre) off += 4;
        e = '{0, 16, rn, 0, up, 0, 0, (lst == 0) ? "R11" : "R2"};
        q.push_back(e);
        for (int r = 0; r < 16; r++) begin
            if (lst[r]) begin
                int k;
                if (!ld) k = 3;
                else if (usr && r15 && r == 15) k = 2;
                else k = 1;
                e = '{k, r, 16, off & 8'hFF, up, (usr && !r15) ? 1 : 0, 0,
                      (k == 2) ? "R7" : "R3"};
                q.push_back(e);
                off = up ? off + 4 : off - 4;
            end
        end
        if (wb) begin
            e = '{up ? 4 : 5, rn, rn, pop * 4, up, 0, 0, (lst == 0) ? "R11" : "R8"};
            q.push_back(e);
        end
        q[q.size() - 1].last = 1;

        @(negedge clk);
        in_valid = 1'b1; in_base = rn; in_list = lst; in_pre = pre;
        in_up = up; in_user = usr; in_wb = wb; in_load = ld;
        @(posedge clk);
        @(negedge clk);
        in_list = ~lst; in_base = ~rn; in_load = ~ld; in_up = ~up; in_wb = ~wb;
        while (q.size() > 0) begin
            bit first_x = (fired == 1);
            chk(in_ready == 1'b0, "R10 busy", in_ready, 0);
            chk(out_valid == 1'b1, "R1 valid", out_valid, 1);
            chk(out_kind == q[0].kind[2:0], q[0].tag, out_kind, q[0].kind);
            chk(out_reg == q[0].rg[4:0], q[0].tag, out_reg, q[0].rg);
            chk(out_base == q[0].base[4:0], q[0].tag, out_base, q[0].base);
            chk(out_off == q[0].off[7:0], first_x ? "R4 off" : "R5 off", out_off, q[0].off);
            chk(out_up == q[0].up[0], "R5 up", out_up, q[0].up);
            chk(out_usr == q[0].usr[0], "R6 usr", out_usr, q[0].usr);
            chk(out_last == q[0].last[0], "R9 last", out_last, q[0].last);
            out_ready = (stall == 0) || (c % stall != 0);
            @(posedge clk);
            if (out_ready) begin
                void'(q.pop_front());
                fired++;
            end
            @(negedge clk);
            c++;
        end
        in_valid = 1'b0;
        out_ready = 1'b0;
        chk(fired == pop + 1 + (wb ? 1 : 0), "R1 count", fired, pop + 1 + (wb ? 1 : 0));
        chk(out_valid == 1'b0 && in_ready == 1'b1, "R10 idle", {out_valid, in_ready}, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(in_ready == 1'b1, "R10 reset ready", in_ready, 1);
        chk(out_valid == 1'b0, "R10 reset valid", out_valid, 0);
        run(4'd3,  16'h00A5, 1, 1, 0, 1, 1, 0);
        run(4'd13, 16'h8003, 0, 0, 0, 1, 0, 3);
        run(4'd2,  16'h8010, 1, 1, 1, 0, 1, 2);   // R7 with last on same uop
        run(4'd9,  16'h0F00, 0, 1, 1, 0, 0, 0);   // R6 force user
        run(4'd1,  16'h8001, 1, 0, 1, 0, 0, 0);   // R6 off, store with r15
        run(4'd7,  16'h0000, 1, 0, 0, 1, 1, 2);   // R11 empty with writeback
        run(4'd5,  16'h0000, 0, 1, 0, 0, 0, 0);   // R11 empty alone
        run(4'd0,  16'hFFFF, 1, 0, 0, 1, 1, 2);
        run(4'd11, 16'h8000, 0, 0, 1, 1, 1, 3);   // R7 then R8
        run(4'd15, 16'h4000, 0, 1, 0, 1, 0, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule